// File: doc/BRIEF.md
# Correlating Two-Level Branch Direction Predictor

This block guesses whether a conditional branch will be taken. It keeps a short shift register with the outcomes of the most recently resolved branches. It also holds one bank of 2-bit saturating counters for every value that register can take. At fetch, a branch address is presented and a taken/not-taken guess comes back in the same cycle. The guess is read from the bank chosen by the current history, at the entry chosen by the low address bits. Because the bank follows the recent history, the same branch can be predicted differently depending on how the branches just before it went.

When a branch is resolved later, the resolve side presents its address, the real outcome and a valid strobe. In that clock edge the block first moves the chosen counter one step toward the outcome, using the history value held before the edge. It then shifts the outcome into the history.

Both sides are plain strobed inputs with no back-pressure. The block is always ready: a lookup is answered combinationally in the cycle it is presented, and a resolve strobe is consumed on the next rising clock edge. No ready signal exists, and the caller never has to hold a request.

Top module: `corr_branch_predictor`

## Requirements
- R1: After reset every counter in every bank is 0 and the history is 0, so every lookup predicts not-taken (`pred_taken` = 0).
- R2: A lookup is answered combinationally in the same cycle. The answer comes from the bank selected by the current history value, and it is taken when that counter holds 2 or 3.
- R3: A resolve moves the selected counter one step toward the outcome: +1 if taken, −1 if not taken. The counter saturates at 3 and at 0 and never wraps.
- R4: Starting from the strongly taken state (3), one not-taken resolve leaves the prediction at taken (state 2).
- R5: On a resolve, the counter is updated in the bank chosen by the history before the edge. The history then shifts left and the outcome enters at bit 0, so two resolves with outcomes a then b leave history = {a,b}.
- R6: Each history value has its own counters. Training an entry under one history value does not change the prediction for the same address under any other history value.
- R7: When a lookup and a resolve hit the same entry in the same cycle, the lookup returns the counter value from before the update.
- R8: The entry index is `pc[ALIGN_W+IDX_W-1:ALIGN_W]` (bits 7:2 by default). Addresses that differ only in the two alignment bits share an entry. Addresses that differ by 256 also share an entry.
- R9: `pred_valid` equals `lk_valid`, and `pred_taken` is 0 whenever `lk_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| lk_valid | input | 1 | Lookup request strobe |
| lk_pc | input | PC_W | Address of the branch being fetched |
| pred_valid | output | 1 | Prediction valid, same cycle as lookup |
| pred_taken | output | 1 | 1 = predicted taken |
| rs_valid | input | 1 | Resolved branch strobe |
| rs_pc | input | PC_W | Address of the resolved branch |
| rs_taken | input | 1 | Actual outcome, 1 = taken |

## Verification
The hardest condition to reach from the ports is a chosen history value at the moment of a lookup or an update, because every resolve also rewrites the history. The bench handles this with a helper that resolves two branches at a scratch address, placed in an entry no test uses, with outcomes equal to the two wanted history bits. This sets the history to any of its four values just before each measured step. It also makes the bit order visible, since training under history 10 must not show up under 01. The same-cycle collision is produced by raising the lookup and the resolve strobes on the same falling edge and sampling the prediction before the rising edge.

// File: rtl/bp_pkg.sv
package bp_pkg;
  // 2-bit saturating direction counter
  typedef logic [1:0] ctr_t;

  localparam ctr_t CTR_MIN = 2'd0;
  localparam ctr_t CTR_MAX = 2'd3;

  // one step toward the observed outcome, clamped at both ends
  function automatic ctr_t ctr_step(input ctr_t cur, input logic taken);
    ctr_t nxt;
    if (taken) nxt = (cur == CTR_MAX) ? cur : ctr_t'(cur + 2'd1);
    else       nxt = (cur == CTR_MIN) ? cur : ctr_t'(cur - 2'd1);
    return nxt;
  endfunction

  // upper half of the range means taken
  function automatic logic ctr_says_taken(input ctr_t cur);
    return cur[1];
  endfunction
endpackage

// File: rtl/bp_ghr.sv
module bp_ghr #(
  parameter int HIST_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift_en,
  input  logic              shift_bit,
  output logic [HIST_W-1:0] hist
);
  logic [HIST_W-1:0] hist_q;

  always_ff @(posedge clk) begin
    if (!rst_n)        hist_q <= '0;
    else if (shift_en) hist_q <= {hist_q[HIST_W-2:0], shift_bit};
  end

  assign hist = hist_q;

  // R5
  ghr_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> hist == {$past(hist[HIST_W-2:0]), $past(shift_bit)});

  // R5
  ghr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_en |=> $stable(hist));
endmodule

// File: rtl/bp_ctr_bank.sv
module bp_ctr_bank
  import bp_pkg::*;
#(
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output ctr_t             rd_ctr,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_taken
);
  localparam int DEPTH = 1 << IDX_W;

  ctr_t cells [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) cells[i] <= CTR_MIN;
    end else if (wr_en) begin
      cells[wr_idx] <= ctr_step(cells[wr_idx], wr_taken);
    end
  end

  // read returns the value held before any same-edge write
  assign rd_ctr = cells[rd_idx];

  // R3
  sat_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_taken && cells[wr_idx] == CTR_MAX) |=> cells[$past(wr_idx)] == CTR_MAX);

  // R3
  sat_bottom_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_taken && cells[wr_idx] == CTR_MIN) |=> cells[$past(wr_idx)] == CTR_MIN);

  // R4
  strong_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_taken && cells[wr_idx] == CTR_MAX) |=> cells[$past(wr_idx)][1]);

  // R6
  cell_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> cells[$past(rd_idx)] == $past(rd_ctr));
endmodule

// File: rtl/corr_branch_predictor.sv
module corr_branch_predictor
  import bp_pkg::*;
#(
  parameter int PC_W    = 32,
  parameter int ALIGN_W = 2,
  parameter int IDX_W   = 6,
  parameter int HIST_W  = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            lk_valid,
  input  logic [PC_W-1:0] lk_pc,
  output logic            pred_valid,
  output logic            pred_taken,
  input  logic            rs_valid,
  input  logic [PC_W-1:0] rs_pc,
  input  logic            rs_taken
);
  localparam int NBANK = 1 << HIST_W;

  logic [HIST_W-1:0] hist;
  logic [IDX_W-1:0]  lk_idx;
  logic [IDX_W-1:0]  rs_idx;
  logic [NBANK-1:0]  bank_we;
  ctr_t              bank_ctr [NBANK];
  ctr_t              sel_ctr;

  assign lk_idx = lk_pc[ALIGN_W +: IDX_W];
  assign rs_idx = rs_pc[ALIGN_W +: IDX_W];

  bp_ghr #(.HIST_W(HIST_W)) u_ghr (
    .clk      (clk),
    .rst_n    (rst_n),
    .shift_en (rs_valid),
    .shift_bit(rs_taken),
    .hist     (hist)
  );

  for (genvar g = 0; g < NBANK; g++) begin : g_bank
    // the bank that matches the pre-edge history takes the update
    assign bank_we[g] = rs_valid && (hist == HIST_W'(g));

    bp_ctr_bank #(.IDX_W(IDX_W)) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .rd_idx  (lk_idx),
      .rd_ctr  (bank_ctr[g]),
      .wr_en   (bank_we[g]),
      .wr_idx  (rs_idx),
      .wr_taken(rs_taken)
    );
  end

  assign sel_ctr    = bank_ctr[hist];
  assign pred_valid = lk_valid;
  assign pred_taken = lk_valid && ctr_says_taken(sel_ctr);

  // R6
  one_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bank_we) && (rs_valid == (bank_we != '0)));

  // R9
  pred_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |-> !pred_taken && !pred_valid);
endmodule

// File: tb/corr_branch_predictor_bench.sv
module corr_branch_predictor_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lk_valid = 1'b0;
  logic [31:0] lk_pc = '0;
  logic        pred_valid;
  logic        pred_taken;
  logic        rs_valid = 1'b0;
  logic [31:0] rs_pc = '0;
  logic        rs_taken = 1'b0;

  int tests = 0;
  int fails = 0;

  localparam logic [31:0] PC_S = 32'd252; // scratch, index 63
  localparam logic [31:0] PC_A = 32'd20;  // index 5
  localparam logic [31:0] PC_B = 32'd36;  // index 9
  localparam logic [31:0] PC_C = 32'd48;  // index 12

  always #5 clk = ~clk;

  corr_branch_predictor u_corr_branch_predictor (
    .clk(clk), .rst_n(rst_n),
    .lk_valid(lk_valid), .lk_pc(lk_pc),
    .pred_valid(pred_valid), .pred_taken(pred_taken),
    .rs_valid(rs_valid), .rs_pc(rs_pc), .rs_taken(rs_taken)
  );

  task automatic check(input logic got, input logic exp, input string tag);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic resolve(input logic [31:0] pc, input logic t);
    @(negedge clk);
    rs_valid = 1'b1; rs_pc = pc; rs_taken = t;
    @(posedge clk); #1;
    rs_valid = 1'b0;
  endtask

  // history = {h[1],h[0]} after two scratch resolves
  task automatic set_hist(input logic [1:0] h);
    resolve(PC_S, h[1]);
    resolve(PC_S, h[0]);
  endtask

  task automatic lookup(input logic [31:0] pc, input logic exp, input string tag);
    @(negedge clk);
    lk_valid = 1'b1; lk_pc = pc;
    #1;
    check(pred_taken, exp, tag);
    lk_valid = 1'b0;
  endtask

  task automatic t_reset();
    lookup(32'd0, 1'b0, "R1 pc0");
    lookup(PC_A, 1'b0, "R1 pcA");
    lookup(PC_S, 1'b0, "R1 pcS");
    @(negedge clk); lk_valid = 1'b0; lk_pc = PC_A; #1;
    check(pred_valid, 1'b0, "R9 valid low");
    check(pred_taken, 1'b0, "R9 taken low");
    lk_valid = 1'b1; #1;
    check(pred_valid, 1'b1, "R9 valid high");
    lk_valid = 1'b0;
  endtask

  task automatic t_train();
    set_hist(2'b00); resolve(PC_A, 1'b1);
    set_hist(2'b00); resolve(PC_A, 1'b1);   // bank0[A] = 2
    set_hist(2'b00); lookup(PC_A, 1'b1, "R2 bank0 taken");
    for (int h = 1; h < 4; h++) begin
      set_hist(2'(h)); lookup(PC_A, 1'b0, "R6 other bank");
    end
  endtask

  task automatic t_saturate();
    set_hist(2'b00); resolve(PC_A, 1'b1);   // 3
    set_hist(2'b00); resolve(PC_A, 1'b1);   // stays 3
    set_hist(2'b00); resolve(PC_A, 1'b0);   // 2
    set_hist(2'b00); lookup(PC_A, 1'b1, "R4 one miss keeps taken");
    set_hist(2'b00); resolve(PC_A, 1'b0);   // 1
    set_hist(2'b00); lookup(PC_A, 1'b0, "R3 step down");
    set_hist(2'b11); resolve(PC_B, 1'b0);   // stays 0
    set_hist(2'b11); resolve(PC_B, 1'b1);   // 1
    set_hist(2'b11); lookup(PC_B, 1'b0, "R3 floor saturation");
  endtask

  task automatic t_history();
    set_hist(2'b10); resolve(PC_C, 1'b1);
    lookup(PC_C, 1'b0, "R5 history now 01");
    set_hist(2'b10); resolve(PC_C, 1'b1);   // bank2[C] = 2
    set_hist(2'b10); lookup(PC_C, 1'b1, "R5 bank 10 trained");
    set_hist(2'b01); lookup(PC_C, 1'b0, "R5 bit order");
  endtask

  task automatic t_same_cycle();
    set_hist(2'b00);                        // bank0[A] = 1
    @(negedge clk);
    lk_valid = 1'b1; lk_pc = PC_A;
    rs_valid = 1'b1; rs_pc = PC_A; rs_taken = 1'b1;
    #1;
    check(pred_taken, 1'b0, "R7 old value seen");
    @(posedge clk); #1;
    rs_valid = 1'b0; lk_valid = 1'b0;
    set_hist(2'b00); lookup(PC_A, 1'b1, "R7 update landed");
  endtask

  task automatic t_alias();
    set_hist(2'b00);                        // bank0[A] = 2
    lookup(PC_A + 32'd1, 1'b1, "R8 align bit");
    lookup(PC_A + 32'd3, 1'b1, "R8 align bits");
    lookup(PC_A + 32'd256, 1'b1, "R8 alias 256");
    lookup(PC_A + 32'd4, 1'b0, "R8 next entry");
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    #200_000;
    tests++; fails++;
    $display("FAIL watchdog: got 0 expected 1");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_train();
    t_saturate();
    t_history();
    t_same_cycle();
    t_alias();
    finish_run();
  end
endmodule